// File: doc/BRIEF.md
# DMA Descriptor Transfer Splitter

The splitter accepts one decoded DMA descriptor at a time. A descriptor carries a start address, a total byte count and a direction flag. The splitter cuts the descriptor into a run of bus requests, each no larger than the negotiated size limit for that direction.

For a write, the limit is the smaller of the host's maximum payload size and a build-time write cap. For a read, it is the smaller of the host's maximum read request size and a fixed 512-byte read cap. Both negotiated limits are sampled when the descriptor is accepted.

For every chunk, the block presents two commands at the same time:
- one to the request constructor, with the address, the length and the total number of requests for the descriptor;
- one to the user-side source/sink agent, with the address, the length and start-of-packet and end-of-packet markers.

The two streams have independent valid/ready handshakes. The splitter moves to the next chunk only once both streams have taken the current one. It takes the next descriptor only once every chunk has been delivered on both streams.

Top module: `dma_xfer_splitter`

## Requirements
- R1: After reset, `desc_ready` is 1 and both `con_valid` and `agt_valid` are 0.
- R2: For a write (`desc_write`=1), every chunk is at most min(128 << `mps_code`, WR_CAP) bytes. `mps_code` 0..3 means 128/256/512/1024 bytes, and WR_CAP defaults to 256.
- R3: For a read (`desc_write`=0), every chunk is at most min(128 << `mrrs_code`, 512) bytes, using the same code encoding.
- R4: `con_count` equals ceil(total length / limit) and holds that value on every chunk of the descriptor.
- R5: The first chunk address equals the descriptor address, and each later chunk address is the previous address plus the previous length.
- R6: Every chunk but the last has the full limit length. The last chunk has length (total mod limit), or the full limit when the total divides evenly.
- R7: `agt_sop` is 1 only on the first chunk and `agt_eop` is 1 only on the last chunk. A single-chunk descriptor has both set.
- R8: A zero-length descriptor is accepted, produces no command on either stream, and leaves `desc_ready` at 1.
- R9: `desc_ready` stays 0 while any chunk of the current descriptor has not yet been taken on both streams.
- R10: A command held valid without ready keeps its fields stable. Both streams carry the same chunk sequence, each chunk exactly once, whatever the ready patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Splitter idle, will take a descriptor |
| desc_addr | input | ADDR_W | Descriptor start address |
| desc_len | input | LEN_W | Descriptor total bytes |
| desc_write | input | 1 | 1 = write, 0 = read |
| mps_code | input | 2 | Negotiated max payload size code |
| mrrs_code | input | 2 | Negotiated max read request size code |
| con_valid | output | 1 | Constructor command valid |
| con_ready | input | 1 | Constructor accepts command |
| con_addr | output | ADDR_W | Chunk address |
| con_len | output | LEN_W | Chunk length |
| con_count | output | LEN_W | Request count for the descriptor |
| con_write | output | 1 | Chunk direction |
| agt_valid | output | 1 | Agent command valid |
| agt_ready | input | 1 | Agent accepts command |
| agt_addr | output | ADDR_W | Chunk address |
| agt_len | output | LEN_W | Chunk length |
| agt_sop | output | 1 | First chunk marker |
| agt_eop | output | 1 | Last chunk marker |
| agt_write | output | 1 | Chunk direction |

## Verification
The bench targets four groups of cases:
- Exact multiples of the limit, where a design that computes the remainder naively would emit a zero-length last chunk or one chunk too many.
- Write requests whose negotiated size exceeds the write cap, and reads that ask for 1024 bytes, where a missing clamp shows up as oversized chunks.
- Single-chunk and zero-length descriptors, which expose wrong sop/eop framing or a phantom command.
- Ready patterns that differ between the two streams, which catch a design that advances on one handshake only: it would drop or duplicate a chunk on the slower stream, or accept a new descriptor early.

// File: rtl/dma_split_pkg.sv
// Shared constants and helpers for the descriptor splitter.
// Assumes size codes are 2 bits, code n meaning 128 << n bytes.
package dma_split_pkg;
    localparam int SHIFT_W      = 4;
    localparam int BASE_SHIFT   = 7;   // 128 bytes
    localparam int RD_CAP_SHIFT = 9;   // reads never exceed 512 bytes

    // Smaller of two shift values.
    function automatic logic [SHIFT_W-1:0] min_shift(input logic [SHIFT_W-1:0] a,
                                                     input logic [SHIFT_W-1:0] b);
        return (a < b) ? a : b;
    endfunction
endpackage

// File: rtl/dma_split_limit.sv
// Picks the chunk size (as a power-of-two shift) for one descriptor.
// Writes use the payload-size code clamped to the write cap; reads use
// the read-request code clamped to 512 bytes. Purely combinational.
module dma_split_limit
    import dma_split_pkg::*;
#(
    parameter int WR_CAP = 256
) (
    input  logic               is_write,
    input  logic [1:0]         mps_code,
    input  logic [1:0]         mrrs_code,
    output logic [SHIFT_W-1:0] lim_shift
);
    localparam int WR_CAP_SHIFT = $clog2(WR_CAP);

    logic [SHIFT_W-1:0] mps_shift;
    logic [SHIFT_W-1:0] mrrs_shift;

    // Translate codes to shifts and clamp against the direction cap.
    always_comb begin
        mps_shift  = SHIFT_W'(BASE_SHIFT) + SHIFT_W'(mps_code);
        mrrs_shift = SHIFT_W'(BASE_SHIFT) + SHIFT_W'(mrrs_code);
        if (is_write)
            lim_shift = min_shift(mps_shift, SHIFT_W'(WR_CAP_SHIFT));
        else
            lim_shift = min_shift(mrrs_shift, SHIFT_W'(RD_CAP_SHIFT));
    end

    initial begin
        assert (WR_CAP == 128 || WR_CAP == 256 || WR_CAP == 512)
            else $error("WR_CAP must be 128, 256 or 512");
    end
endmodule

// File: rtl/dma_split_walker.sv
// Holds the descriptor being split and walks it chunk by chunk.
// Assumes 'advance' is raised only while busy, once both output streams
// have taken the current chunk. A zero-length descriptor is accepted
// and dropped.
module dma_split_walker
    import dma_split_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic [ADDR_W-1:0]  in_addr,
    input  logic [LEN_W-1:0]   in_len,
    input  logic               in_write,
    input  logic [SHIFT_W-1:0] in_shift,
    input  logic               advance,
    output logic               busy,
    output logic [ADDR_W-1:0]  chunk_addr,
    output logic [LEN_W-1:0]   chunk_len,
    output logic [LEN_W-1:0]   chunk_total,
    output logic               chunk_first,
    output logic               chunk_last,
    output logic               chunk_write
);
    localparam int WIDE_W = LEN_W + 1;

    logic [LEN_W-1:0]   remain_q;
    logic [SHIFT_W-1:0] shift_q;
    logic [WIDE_W-1:0]  lim_bytes;
    logic [WIDE_W-1:0]  in_lim;
    logic [WIDE_W-1:0]  in_count;

    // Chunk size of the held descriptor, and the count for a new one.
    always_comb begin
        lim_bytes = WIDE_W'(1) << shift_q;
        in_lim    = WIDE_W'(1) << in_shift;
        in_count  = ({1'b0, in_len} + in_lim - WIDE_W'(1)) >> in_shift;
    end

    // The current chunk is the remainder, capped at the limit.
    always_comb begin
        chunk_last = ({1'b0, remain_q} <= lim_bytes);
        chunk_len  = chunk_last ? remain_q : lim_bytes[LEN_W-1:0];
    end

    // Load on accept, step address and remainder on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            chunk_addr  <= '0;
            remain_q    <= '0;
            shift_q     <= SHIFT_W'(BASE_SHIFT);
            chunk_total <= '0;
            chunk_first <= 1'b0;
            chunk_write <= 1'b0;
        end else if (accept) begin
            busy        <= (in_len != '0);
            chunk_addr  <= in_addr;
            remain_q    <= in_len;
            shift_q     <= in_shift;
            chunk_total <= in_count[LEN_W-1:0];
            chunk_first <= 1'b1;
            chunk_write <= in_write;
        end else if (advance) begin
            if (chunk_last) begin
                busy <= 1'b0;
            end else begin
                chunk_addr  <= chunk_addr + ADDR_W'(chunk_len);
                remain_q    <= remain_q - chunk_len;
                chunk_first <= 1'b0;
            end
        end
    end

    AST_NONLAST_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !chunk_last |-> {1'b0, chunk_len} == lim_bytes) else $error("non-last short"); // R6
    AST_NO_EMPTY_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> chunk_len != '0) else $error("empty chunk"); // R8
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !accept) else $error("accept while busy"); // R9
endmodule

// File: rtl/dma_split_fork.sv
// Shares each chunk between two valid/ready streams. A per-stream flag
// records a completed handshake; the chunk retires once every stream
// has it. Assumes the chunk fields stay constant while busy and not
// advancing.
module dma_split_fork #(
    parameter int N_OUT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic [N_OUT-1:0] out_ready,
    output logic [N_OUT-1:0] out_valid,
    output logic             advance
);
    logic [N_OUT-1:0] taken_q;
    logic [N_OUT-1:0] fire;

    for (genvar g = 0; g < N_OUT; g++) begin : g_stream
        // Offer the chunk until this stream has taken it.
        assign out_valid[g] = busy && !taken_q[g];
        assign fire[g]      = out_valid[g] && out_ready[g];

        // Remember the handshake until the chunk retires.
        always_ff @(posedge clk) begin
            if (!rst_n)       taken_q[g] <= 1'b0;
            else if (advance) taken_q[g] <= 1'b0;
            else if (fire[g]) taken_q[g] <= 1'b1;
        end
    end

    // Retire once every stream has completed its handshake.
    assign advance = busy && (&(taken_q | fire));

    AST_TAKEN_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> taken_q == '0) else $error("stale taken flag"); // R10
endmodule

// File: rtl/dma_xfer_splitter.sv
// Top of the descriptor splitter: selects the chunk limit, walks the
// descriptor and forks each chunk to the constructor and agent streams.
// Assumes the negotiated size codes are valid while desc_valid is high.
module dma_xfer_splitter
    import dma_split_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 20,
    parameter int WR_CAP = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic [LEN_W-1:0]  desc_len,
    input  logic              desc_write,
    input  logic [1:0]        mps_code,
    input  logic [1:0]        mrrs_code,
    output logic              con_valid,
    input  logic              con_ready,
    output logic [ADDR_W-1:0] con_addr,
    output logic [LEN_W-1:0]  con_len,
    output logic [LEN_W-1:0]  con_count,
    output logic              con_write,
    output logic              agt_valid,
    input  logic              agt_ready,
    output logic [ADDR_W-1:0] agt_addr,
    output logic [LEN_W-1:0]  agt_len,
    output logic              agt_sop,
    output logic              agt_eop,
    output logic              agt_write
);
    logic [SHIFT_W-1:0] lim_shift;
    logic               busy;
    logic               advance;
    logic               accept;
    logic [ADDR_W-1:0]  c_addr;
    logic [LEN_W-1:0]   c_len;
    logic [LEN_W-1:0]   c_total;
    logic               c_first;
    logic               c_last;
    logic               c_write;
    logic [1:0]         valids;

    assign desc_ready = !busy;
    assign accept     = desc_valid && desc_ready;

    dma_split_limit #(.WR_CAP(WR_CAP)) u_limit (
        .is_write (desc_write),
        .mps_code (mps_code),
        .mrrs_code(mrrs_code),
        .lim_shift(lim_shift)
    );

    dma_split_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .in_addr    (desc_addr),
        .in_len     (desc_len),
        .in_write   (desc_write),
        .in_shift   (lim_shift),
        .advance    (advance),
        .busy       (busy),
        .chunk_addr (c_addr),
        .chunk_len  (c_len),
        .chunk_total(c_total),
        .chunk_first(c_first),
        .chunk_last (c_last),
        .chunk_write(c_write)
    );

    dma_split_fork #(.N_OUT(2)) u_fork (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .out_ready({agt_ready, con_ready}),
        .out_valid(valids),
        .advance  (advance)
    );

    // Fan the shared chunk fields out to both command streams.
    always_comb begin
        con_valid = valids[0];
        agt_valid = valids[1];
        con_addr  = c_addr;
        con_len   = c_len;
        con_count = c_total;
        con_write = c_write;
        agt_addr  = c_addr;
        agt_len   = c_len;
        agt_sop   = c_first;
        agt_eop   = c_last;
        agt_write = c_write;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        desc_ready |-> !con_valid && !agt_valid) else $error("command while idle"); // R9
    AST_CON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        con_valid && !con_ready |=> con_valid && $stable(con_addr) && $stable(con_len))
        else $error("con command changed under stall"); // R10
    AST_AGT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        agt_valid && !agt_ready |=> agt_valid && $stable(agt_addr) && $stable(agt_sop))
        else $error("agent command changed under stall"); // R10
    AST_SINGLE_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
        agt_valid && con_count == LEN_W'(1) |-> agt_sop && agt_eop)
        else $error("single chunk not framed"); // R7
endmodule

// File: tb/tb_dma_xfer_splitter.sv
// Scoreboard bench: the driver predicts every chunk into two queues,
// monitors pop and compare on each handshake.
module tb_dma_xfer_splitter;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 20;
    localparam int WR_CAP = 256;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  count;
        logic              sop;
        logic              eop;
        logic              wr;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic desc_valid = 1'b0;
    logic desc_ready;
    logic [ADDR_W-1:0] desc_addr = '0;
    logic [LEN_W-1:0]  desc_len = '0;
    logic desc_write = 1'b0;
    logic [1:0] mps_code = '0;
    logic [1:0] mrrs_code = '0;
    logic con_valid, con_ready, con_write;
    logic [ADDR_W-1:0] con_addr;
    logic [LEN_W-1:0]  con_len, con_count;
    logic agt_valid, agt_ready, agt_sop, agt_eop, agt_write;
    logic [ADDR_W-1:0] agt_addr;
    logic [LEN_W-1:0]  agt_len;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    int ready_mode = 0;
    exp_t q_con[$];
    exp_t q_agt[$];

    always #10 clk = ~clk; // 50 MHz

    dma_xfer_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .WR_CAP(WR_CAP)) dut (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Predict chunks (R2..R7) and offer the descriptor.
    task automatic send(input logic [ADDR_W-1:0] a, input int len, input bit wr,
                        input int mps, input int mrrs);
        int cap, lim, cnt, rem;
        logic [ADDR_W-1:0] ad;
        bit acc;
        exp_t e;
        cap = wr ? (128 << mps) : (128 << mrrs);
        lim = wr ? ((cap < WR_CAP) ? cap : WR_CAP) : ((cap < 512) ? cap : 512);
        cnt = (len + lim - 1) / lim;
        rem = len;
        ad  = a;
        for (int i = 0; i < cnt; i++) begin
            e.addr  = ad;
            e.len   = LEN_W'((rem > lim) ? lim : rem);
            e.count = LEN_W'(cnt);
            e.sop   = (i == 0);
            e.eop   = (i == cnt - 1);
            e.wr    = wr;
            q_con.push_back(e);
            q_agt.push_back(e);
            ad  = ad + ADDR_W'(e.len);
            rem = rem - int'(e.len);
        end
        @(posedge clk); #1;
        desc_valid = 1'b1; desc_addr = a; desc_len = LEN_W'(len);
        desc_write = wr; mps_code = 2'(mps); mrrs_code = 2'(mrrs);
        do begin
            @(negedge clk); acc = desc_ready;
            @(posedge clk); #1;
        end while (!acc);
        desc_valid = 1'b0;
    endtask

    task automatic drain();
        while (q_con.size() != 0 || q_agt.size() != 0) @(posedge clk);
        @(negedge clk);
    endtask

    // Ready generators: mode 0 both high, 1 random, 2 con slow / agt fast.
    always @(posedge clk) begin
        #1;
        case (ready_mode)
            0: begin con_ready = 1'b1; agt_ready = 1'b1; end
            1: begin con_ready = $urandom_range(0, 1) == 1; agt_ready = $urandom_range(0, 1) == 1; end
            default: begin con_ready = ($urandom_range(0, 3) == 0); agt_ready = 1'b1; end
        endcase
    end

    // Monitors: compare handshakes against the queues, check R9/R10.
    logic p_cv = 1'b0, p_cr = 1'b0, p_av = 1'b0, p_ar = 1'b0;
    logic [ADDR_W-1:0] p_ca, p_aa;
    logic [LEN_W-1:0] p_cl;
    always @(negedge clk) begin
        if (rst_n) begin
            exp_t e;
            if ((con_valid || agt_valid) && desc_ready)
                check(0, "R9", "ready while chunk pending", 1, 0);
            if (p_cv && !p_cr)
                check(con_valid && con_addr == p_ca && con_len == p_cl, "R10",
                      "con hold addr", longint'(con_addr), longint'(p_ca));
            if (p_av && !p_ar)
                check(agt_valid && agt_addr == p_aa, "R10", "agt hold addr",
                      longint'(agt_addr), longint'(p_aa));
            if (con_valid && con_ready) begin
                if (q_con.size() == 0) check(0, "R10", "unexpected con chunk", longint'(con_addr), -1);
                else begin
                    e = q_con.pop_front();
                    check(con_addr == e.addr, "R5", "con_addr", longint'(con_addr), longint'(e.addr));
                    check(con_len == e.len, e.wr ? "R2/R6" : "R3/R6", "con_len", con_len, e.len);
                    check(con_count == e.count, "R4", "con_count", con_count, e.count);
                    check(con_write == e.wr, "R10", "con_write", con_write, e.wr);
                end
            end
            if (agt_valid && agt_ready) begin
                if (q_agt.size() == 0) check(0, "R10", "unexpected agt chunk", longint'(agt_addr), -1);
                else begin
                    e = q_agt.pop_front();
                    check(agt_addr == e.addr, "R5", "agt_addr", longint'(agt_addr), longint'(e.addr));
                    check(agt_len == e.len, "R6", "agt_len", agt_len, e.len);
                    check(agt_sop == e.sop, "R7", "agt_sop", agt_sop, e.sop);
                    check(agt_eop == e.eop, "R7", "agt_eop", agt_eop, e.eop);
                end
            end
        end
        p_cv = con_valid; p_cr = con_ready; p_ca = con_addr; p_cl = con_len;
        p_av = agt_valid; p_ar = agt_ready; p_aa = agt_addr;
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            check(0, "WDOG", "run hung", cycles, 150000);
            finish_run();
        end
    end

    initial begin
        con_ready = 1'b1; agt_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(desc_ready == 1'b1, "R1", "desc_ready after reset", desc_ready, 1);
        check(!con_valid && !agt_valid, "R1", "valids after reset", con_valid, 0);
        #1; rst_n = 1'b1;

        // R2: writes capped at WR_CAP even when 1024 negotiated; exact multiple.
        send(32'h1000, 1024, 1, 3, 0); drain();
        // R2: small payload size, remainder last chunk (R6).
        send(32'h2004, 300, 1, 0, 3); drain();
        // R3: read with 1024 negotiated clamps to 512.
        send(32'h8000, 1300, 0, 0, 3); drain();
        // R3: read with 256 limit, exact multiple (R6).
        send(32'h9000, 768, 0, 3, 1); drain();
        // R7: single chunk gets sop and eop.
        send(32'hA000, 64, 1, 2, 0); drain();
        send(32'hA100, 256, 1, 2, 0); drain();
        // R8: zero length produces nothing, ready stays high.
        send(32'hB000, 0, 1, 1, 1);
        repeat (4) begin
            @(negedge clk);
            check(!con_valid && !agt_valid, "R8", "valid after zero-length", con_valid, 0);
            check(desc_ready, "R8", "ready after zero-length", desc_ready, 1);
        end
        // R10/R9: random and skewed ready patterns, back-to-back descriptors.
        ready_mode = 1;
        send(32'hC000, 1000, 1, 1, 0);
        send(32'hD000, 2049, 0, 2, 2);
        send(32'hE000, 129, 1, 0, 0);
        drain();
        ready_mode = 2;
        send(32'hF000, 1536, 0, 3, 3);
        send(32'hF800, 700, 1, 3, 3);
        drain();
        ready_mode = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(q_con.size() == 0 && q_agt.size() == 0, "R10", "leftover expected chunks",
              q_con.size() + q_agt.size(), 0);
        check(desc_ready, "R9", "ready after all chunks", desc_ready, 1);
        finish_run();
    end
endmodule